// File: doc/BRIEF.md
# Unified Data-Space Load/Store Unit

This block generates addresses and steers data for the load and store operations of an 8-bit controller with many registers. The instruction decoder hands it an operation already split into fields: load or store, addressing mode, pointer-pair select, a 6-bit displacement, a 16-bit direct address and the byte to store. The unit forms the effective address and updates the pointer pair when the mode calls for it. It then sends the access to one of three targets that share a single linear 16-bit data space: the 32 working registers, the I/O register bank or the data SRAM. For loads it returns the byte that was read.

The pointer pairs are themselves working registers. The unit reads the selected pair through a dedicated two-byte read port, and it writes the updated pair back through a 16-bit write port in the same cycle as the access. The working registers and the I/O bank have combinational read ports. The SRAM has a registered read that is one cycle deep. All three storage blocks sit outside this unit.

Top module: `dspace_lsu`

## Requirements
- R1: Effective addresses 0x0000 to 0x001F select working register R0 to R31 (rf_addr_o = address bits 4:0). A load returns that register's byte and a store overwrites it.
- R2: Effective addresses 0x0020 to 0x00FF go to the I/O port with io_addr_o = address − 0x20. This covers the 64 standard I/O registers at 0x20–0x5F and the extended registers at 0x60–0xFF.
- R3: Effective addresses from 0x0100 to 0x0100+SRAM_BYTES−1 go to the SRAM with sram_addr_o = address − 0x100. Above that range a load returns 0x00, a store changes nothing and no target is enabled.
- R4: ptr_sel_i selects the pointer pair: 0 = X (R27:R26), 1 = Y (R29:R28), 2 = Z (R31:R30). mode_i selects the addressing mode: 0 = direct, 1 = pointer, 2 = pointer with post-increment, 3 = pointer with pre-decrement, 4 = pointer plus displacement. Plain pointer mode accesses the pointer value and leaves the pair unchanged.
- R5: In post-increment mode the access uses the current pointer, and the pointer plus one is written back to the pair.
- R6: In pre-decrement mode the access uses the pointer minus one, and that same value is written back to the pair.
- R7: Displacement mode adds the unsigned 6-bit disp_i (0 to 63) to Y or Z for this access only, and the pointer is not written. The following combinations are rejected: displacement mode with X, any pointer mode with ptr_sel_i = 3, and mode_i values 5 to 7. A rejected request writes nothing, returns 0x00 and completes after 1 cycle.
- R8: Both pointer arithmetic and the sum of pointer and displacement wrap modulo 2^16.
- R9: done_o pulses for exactly one cycle for each accepted request. It comes 1 cycle after acceptance for a pointer access to a register or I/O address. It comes 2 cycles after acceptance for an SRAM access, an access above the SRAM and any direct-mode access. rdata_o is valid while done_o is high and is 0x00 for stores.
- R10: Direct mode uses dir_addr_i as the full 16-bit effective address and never touches a pointer pair.
- R11: A store whose target byte belongs to the pointer pair being updated in the same access loses to the update: the pair receives the new pointer value and the stored byte is dropped.
- R12: A req_i raised while a 2-cycle access is outstanding (after acceptance and before its done) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request; taken when no access is outstanding |
| store_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 3 | Addressing mode |
| ptr_sel_i | input | 2 | Pointer pair select |
| disp_i | input | 6 | Unsigned displacement |
| dir_addr_i | input | 16 | Direct-mode address |
| wdata_i | input | 8 | Store data |
| done_o | output | 1 | Completion strobe |
| rdata_o | output | 8 | Load data |
| ptr_idx_o | output | 5 | Register index of the selected pair's low byte |
| ptr_lo_i | input | 8 | Register at ptr_idx_o |
| ptr_hi_i | input | 8 | Register at ptr_idx_o+1 |
| ptr_we_o | output | 1 | Pointer pair write enable |
| ptr_wval_o | output | 16 | New pointer value |
| rf_addr_o | output | 5 | Working register index |
| rf_rdata_i | input | 8 | Working register read data |
| rf_we_o | output | 1 | Working register write enable |
| wdata_o | output | 8 | Store data to every target |
| io_en_o | output | 1 | I/O access enable |
| io_we_o | output | 1 | I/O write enable |
| io_addr_o | output | 8 | I/O register index |
| io_rdata_i | input | 8 | I/O read data |
| sram_en_o | output | 1 | SRAM access enable |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | SRAM_AW | SRAM byte offset |
| sram_rdata_i | input | 8 | SRAM read data, one cycle after enable |

## Verification
Several properties are checked by assertions on every cycle. At most one target is enabled at a time. An address above the SRAM enables nothing. Displacement mode never writes a pointer. A register store never lands in the pair that is being updated. The done strobe follows acceptance after exactly 1 or 2 cycles, depending on the kind of access. Other behaviour can only be shown by the bench's scenarios, where a reference model tracks every storage byte:

- the values that are loaded and stored;
- the pointer values written back after increment, decrement and wrap-around;
- a displacement that wraps into the I/O range;
- a request that is rejected and leaves storage untouched;
- a request that arrives while an access is outstanding and is dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    MD_DIRECT  = 3'd0,
    MD_PTR     = 3'd1,
    MD_POSTINC = 3'd2,
    MD_PREDEC  = 3'd3,
    MD_DISP    = 3'd4
  } lsu_mode_e;

  typedef enum logic [1:0] {
    RG_REG  = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2,
    RG_NONE = 2'd3
  } lsu_region_e;

  localparam logic [15:0] IO_BASE   = 16'h0020;
  localparam logic [15:0] SRAM_BASE = 16'h0100;
  localparam logic [1:0]  SEL_X     = 2'd0;
  localparam logic [1:0]  SEL_BAD   = 2'd3;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned DISP_W = 6
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [15:0]       dir_addr_i,
  input  logic [15:0]       ptr_i,
  output logic [15:0]       ea_o,
  output logic [15:0]       ptr_new_o,
  output logic              ptr_upd_o,
  output logic              illegal_o
);
  logic upd;

  always_comb begin
    ea_o      = ptr_i;
    ptr_new_o = ptr_i;
    upd       = 1'b0;
    illegal_o = 1'b0;
    case (lsu_mode_e'(mode_i))
      MD_DIRECT:  ea_o = dir_addr_i;
      MD_PTR:     illegal_o = (sel_i == SEL_BAD);
      MD_POSTINC: begin
        ptr_new_o = ptr_i + 16'd1;
        upd       = 1'b1;
        illegal_o = (sel_i == SEL_BAD);
      end
      MD_PREDEC: begin
        ptr_new_o = ptr_i - 16'd1;
        ea_o      = ptr_new_o;
        upd       = 1'b1;
        illegal_o = (sel_i == SEL_BAD);
      end
      MD_DISP: begin
        ea_o      = ptr_i + {{(16-DISP_W){1'b0}}, disp_i};
        illegal_o = (sel_i == SEL_BAD) || (sel_i == SEL_X);
      end
      default: illegal_o = 1'b1;
    endcase
    ptr_upd_o = upd & ~illegal_o;
  end
endmodule

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int unsigned SRAM_BYTES = 512,
  parameter int unsigned SRAM_AW    = $clog2(SRAM_BYTES)
) (
  input  logic [15:0]        ea_i,
  output lsu_region_e        region_o,
  output logic [7:0]         io_addr_o,
  output logic [SRAM_AW-1:0] sram_addr_o
);
  localparam logic [16:0] SRAM_LIMIT = 17'(SRAM_BASE) + 17'(SRAM_BYTES);

  logic [15:0] io_off;
  logic [15:0] sram_off;

  assign io_off      = ea_i - IO_BASE;
  assign sram_off    = ea_i - SRAM_BASE;
  assign io_addr_o   = io_off[7:0];
  assign sram_addr_o = sram_off[SRAM_AW-1:0];

  always_comb begin
    if (ea_i < IO_BASE)                  region_o = RG_REG;
    else if (ea_i < SRAM_BASE)           region_o = RG_IO;
    else if ({1'b0, ea_i} < SRAM_LIMIT)  region_o = RG_SRAM;
    else                                 region_o = RG_NONE;
  end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       slow_i,
  input  logic       sram_load_i,
  input  logic [7:0] fast_data_i,
  input  logic [7:0] sram_rdata_i,
  output logic       idle_o,
  output logic       done_o,
  output logic [7:0] rdata_o
);
  logic       pend_q, from_sram_q, done_q;
  logic [7:0] hold_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      from_sram_q <= 1'b0;
      done_q      <= 1'b0;
      hold_q      <= 8'h00;
      rdata_q     <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (pend_q) begin
        pend_q  <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= from_sram_q ? sram_rdata_i : hold_q;
      end else if (start_i) begin
        if (slow_i) begin
          pend_q      <= 1'b1;
          from_sram_q <= sram_load_i;
          hold_q      <= fast_data_i;
        end else begin
          done_q  <= 1'b1;
          rdata_q <= fast_data_i;
        end
      end
    end
  end

  assign idle_o  = ~pend_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  a_r9_fast_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !slow_i) |=> done_o);
  a_r9_slow_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && slow_i) |=> (!done_o ##1 done_o));
endmodule

// File: rtl/dspace_lsu.sv
module dspace_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned SRAM_BYTES = 512,
  parameter int unsigned DISP_W     = 6,
  parameter int unsigned SRAM_AW    = $clog2(SRAM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               store_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         ptr_sel_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [15:0]        dir_addr_i,
  input  logic [7:0]         wdata_i,
  output logic               done_o,
  output logic [7:0]         rdata_o,
  output logic [4:0]         ptr_idx_o,
  input  logic [7:0]         ptr_lo_i,
  input  logic [7:0]         ptr_hi_i,
  output logic               ptr_we_o,
  output logic [15:0]        ptr_wval_o,
  output logic [4:0]         rf_addr_o,
  input  logic [7:0]         rf_rdata_i,
  output logic               rf_we_o,
  output logic [7:0]         wdata_o,
  output logic               io_en_o,
  output logic               io_we_o,
  output logic [7:0]         io_addr_o,
  input  logic [7:0]         io_rdata_i,
  output logic               sram_en_o,
  output logic               sram_we_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  input  logic [7:0]         sram_rdata_i
);
  localparam logic [4:0] PAIR_BASE = 5'd26;

  logic [15:0] ea, ptr_new;
  logic        ptr_upd, illegal, idle, accept, go, slow, hits_pair;
  logic [7:0]  fast_data;
  lsu_region_e region;

  assign ptr_idx_o = PAIR_BASE + {2'b00, ptr_sel_i, 1'b0};

  lsu_agen #(.DISP_W(DISP_W)) u_agen (
    .mode_i     (mode_i),
    .sel_i      (ptr_sel_i),
    .disp_i     (disp_i),
    .dir_addr_i (dir_addr_i),
    .ptr_i      ({ptr_hi_i, ptr_lo_i}),
    .ea_o       (ea),
    .ptr_new_o  (ptr_new),
    .ptr_upd_o  (ptr_upd),
    .illegal_o  (illegal)
  );

  lsu_decode #(.SRAM_BYTES(SRAM_BYTES), .SRAM_AW(SRAM_AW)) u_dec (
    .ea_i        (ea),
    .region_o    (region),
    .io_addr_o   (io_addr_o),
    .sram_addr_o (sram_addr_o)
  );

  assign accept    = req_i & idle;
  assign go        = accept & ~illegal;
  assign rf_addr_o = ea[4:0];
  assign hits_pair = ptr_upd && (rf_addr_o[4:1] == ptr_idx_o[4:1]);

  // pointer write-back beats a store into the same pair
  assign rf_we_o    = go & store_i & (region == RG_REG) & ~hits_pair;
  assign ptr_we_o   = accept & ptr_upd;
  assign ptr_wval_o = ptr_new;
  assign io_en_o    = go & (region == RG_IO);
  assign io_we_o    = io_en_o & store_i;
  assign sram_en_o  = go & (region == RG_SRAM);
  assign sram_we_o  = sram_en_o & store_i;
  assign wdata_o    = wdata_i;

  assign slow = ~illegal & ((lsu_mode_e'(mode_i) == MD_DIRECT) ||
                            (region == RG_SRAM) || (region == RG_NONE));

  always_comb begin
    fast_data = 8'h00;
    if (!illegal && !store_i) begin
      case (region)
        RG_REG:  fast_data = rf_rdata_i;
        RG_IO:   fast_data = io_rdata_i;
        default: fast_data = 8'h00;
      endcase
    end
  end

  lsu_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .slow_i       (slow),
    .sram_load_i  (sram_en_o & ~store_i),
    .fast_data_i  (fast_data),
    .sram_rdata_i (sram_rdata_i),
    .idle_o       (idle),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rf_we_o, io_en_o, sram_en_o}) <= 1);
  a_r3_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && region == RG_NONE) |-> !(rf_we_o || io_en_o || sram_en_o));
  a_r7_disp_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i == 3'd4) |-> !ptr_we_o);
  a_r11_ptr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && rf_we_o) |-> (rf_addr_o[4:1] != ptr_idx_o[4:1]));
  a_r12_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle) |-> !(rf_we_o || io_en_o || sram_en_o || ptr_we_o));
endmodule

// File: tb/dspace_lsu_test.sv
module dspace_lsu_test;
  localparam int SB = 512;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req = 0, st = 0;
  logic [2:0] mode = 0;
  logic [1:0] sel = 0;
  logic [5:0] disp = 0;
  logic [15:0] daddr = 0;
  logic [7:0] wd = 0;
  logic done; logic [7:0] rdata;
  logic [4:0] pidx; logic [7:0] plo, phi;
  logic pwe; logic [15:0] pval;
  logic [4:0] rfa; logic [7:0] rfr; logic rfwe; logic [7:0] wdo;
  logic ioen, iowe; logic [7:0] ioa, ior;
  logic sen, swe; logic [AW-1:0] sa; logic [7:0] sr;

  logic [7:0] env_rf [32];
  logic [7:0] env_io [224];
  logic [7:0] env_sram [SB];
  logic [7:0] ref_rf [32];
  logic [7:0] ref_io [224];
  logic [7:0] ref_sram [SB];

  dspace_lsu #(.SRAM_BYTES(SB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .store_i(st), .mode_i(mode),
    .ptr_sel_i(sel), .disp_i(disp), .dir_addr_i(daddr), .wdata_i(wd),
    .done_o(done), .rdata_o(rdata), .ptr_idx_o(pidx), .ptr_lo_i(plo),
    .ptr_hi_i(phi), .ptr_we_o(pwe), .ptr_wval_o(pval), .rf_addr_o(rfa),
    .rf_rdata_i(rfr), .rf_we_o(rfwe), .wdata_o(wdo), .io_en_o(ioen),
    .io_we_o(iowe), .io_addr_o(ioa), .io_rdata_i(ior), .sram_en_o(sen),
    .sram_we_o(swe), .sram_addr_o(sa), .sram_rdata_i(sr));

  // storage environment
  assign plo = env_rf[pidx];
  assign phi = env_rf[pidx + 5'd1];
  assign rfr = env_rf[rfa];
  assign ior = (ioa < 8'd224) ? env_io[ioa] : 8'h00;
  always @(posedge clk) begin
    if (rfwe) env_rf[rfa] <= wdo;
    if (pwe) begin env_rf[pidx] <= pval[7:0]; env_rf[pidx + 5'd1] <= pval[15:8]; end
    if (iowe && ioa < 8'd224) env_io[ioa] <= wdo;
    if (sen && swe) env_sram[sa] <= wdo;
    if (sen && !swe) sr <= env_sram[sa];
  end

  int vectors = 0, errors = 0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_rd(int a);
    if (a < 32) return ref_rf[a];
    if (a < 256) return ref_io[a - 32];
    if (a < 256 + SB) return ref_sram[a - 256];
    return 0;
  endfunction

  task automatic ref_wr(int a, int v);
    if (a < 32) ref_rf[a] = 8'(v);
    else if (a < 256) ref_io[a - 32] = 8'(v);
    else if (a < 256 + SB) ref_sram[a - 256] = 8'(v);
  endtask

  task automatic compare_mem(string tag);
    int bad = 0, first = -1, av = 0, ev = 0;
    for (int i = 0; i < 32; i++) if (env_rf[i] !== ref_rf[i]) begin bad++; if (first < 0) begin first = i; av = env_rf[i]; ev = ref_rf[i]; end end
    for (int i = 0; i < 224; i++) if (env_io[i] !== ref_io[i]) begin bad++; if (first < 0) begin first = i + 32; av = env_io[i]; ev = ref_io[i]; end end
    for (int i = 0; i < SB; i++) if (env_sram[i] !== ref_sram[i]) begin bad++; if (first < 0) begin first = i + 256; av = env_sram[i]; ev = ref_sram[i]; end end
    vectors++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s storage at 0x%0h: actual 0x%0h expected 0x%0h", tag, first, av, ev);
    end
  endtask

  task automatic do_op(string tag, bit s, int md, int ps, int dp, int da, int w, bit poke);
    int idx, ptr, ea, np, lat, exp;
    bit bad, upd;
    idx = (26 + 2 * ps) % 32;
    ptr = ref_rf[(idx + 1) % 32] * 256 + ref_rf[idx];
    bad = (md > 4) || (md != 0 && ps == 3) || (md == 4 && ps == 0);
    upd = !bad && (md == 2 || md == 3);
    np = ptr; ea = ptr;
    case (md)
      0: ea = da;
      2: np = (ptr + 1) % 65536;
      3: begin np = (ptr + 65535) % 65536; ea = np; end
      4: ea = (ptr + dp) % 65536;
      default: ;
    endcase
    lat = bad ? 1 : ((md == 0 || ea >= 256) ? 2 : 1);
    exp = (bad || s) ? 0 : ref_rd(ea);
    if (!bad && s) ref_wr(ea, w);
    if (upd) begin ref_rf[idx] = 8'(np); ref_rf[(idx + 1) % 32] = 8'(np >> 8); end

    @(negedge clk);
    check({tag, " R9 done idle"}, int'(done), 0);
    req = 1; st = s; mode = 3'(md); sel = 2'(ps); disp = 6'(dp); daddr = 16'(da); wd = 8'(w);
    @(negedge clk);
    req = 0;
    if (lat == 2) begin
      check({tag, " R9 done wait"}, int'(done), 0);
      if (poke) begin
        req = 1; st = 1; mode = 3'd0; daddr = 16'h0005; wd = 8'hEE;
        @(negedge clk);
        req = 0;
      end else @(negedge clk);
    end
    check({tag, " R9 done"}, int'(done), 1);
    check({tag, " rdata"}, int'(rdata), exp);
    compare_mem(tag);
  endtask

  task automatic set_ptr(int ps, int v);
    do_op("set ptr lo R10", 1, 0, 0, 0, 26 + 2 * ps, v & 255, 0);
    do_op("set ptr hi R10", 1, 0, 0, 0, 27 + 2 * ps, v >> 8, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin env_rf[i] = 8'(i * 7 + 3); ref_rf[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 224; i++) begin env_io[i] = 8'(i * 5 + 1); ref_io[i] = 8'(i * 5 + 1); end
    for (int i = 0; i < SB; i++) begin env_sram[i] = 8'(i * 3 + 9); ref_sram[i] = 8'(i * 3 + 9); end
    sr = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 reset done", int'(done), 0);
    check("R9 reset rdata", int'(rdata), 0);
    rst_n = 1;

    do_op("R10 R1 direct load R3", 0, 0, 0, 0, 16'h0003, 0, 0);
    do_op("R10 R1 direct store R3", 1, 0, 0, 0, 16'h0003, 8'h5A, 0);
    do_op("R2 direct ext io 0x60", 0, 0, 0, 0, 16'h0060, 0, 0);
    do_op("R2 direct store io 0xFF", 1, 0, 0, 0, 16'h00FF, 8'h77, 0);
    do_op("R3 direct sram last", 1, 0, 0, 0, 16'h02FF, 8'hA5, 0);
    do_op("R3 direct sram last load", 0, 0, 0, 0, 16'h02FF, 0, 0);
    do_op("R3 unmapped store", 1, 0, 0, 0, 16'h0300, 8'h11, 0);
    do_op("R3 unmapped load", 0, 0, 0, 0, 16'h0300, 0, 0);
    set_ptr(0, 16'h0003);
    do_op("R4 R1 X plain load", 0, 1, 0, 0, 0, 0, 0);
    do_op("R5 X+ store", 1, 2, 0, 0, 0, 8'hC3, 0);
    do_op("R5 X+ load", 0, 2, 0, 0, 0, 0, 0);
    set_ptr(1, 16'h0025);
    do_op("R6 R2 -Y load io", 0, 3, 1, 0, 0, 0, 0);
    do_op("R6 -Y store io", 1, 3, 1, 0, 0, 8'h3C, 0);
    set_ptr(2, 16'h0100);
    do_op("R7 R3 Z+63 sram store", 1, 4, 2, 63, 0, 8'h96, 0);
    do_op("R7 Z+63 sram load", 0, 4, 2, 63, 0, 0, 0);
    do_op("R7 Z+0 sram load", 0, 4, 2, 0, 0, 0, 0);
    do_op("R7 Y+5 io load", 0, 4, 1, 5, 0, 0, 0);
    do_op("R7 X disp rejected", 1, 4, 0, 3, 0, 8'h44, 0);
    do_op("R7 sel3 rejected", 1, 2, 3, 0, 0, 8'h44, 0);
    do_op("R7 mode6 rejected", 0, 6, 1, 0, 0, 0, 0);
    set_ptr(2, 16'hFFF0);
    do_op("R8 Z disp wraps to io", 0, 4, 2, 63, 0, 0, 0);
    set_ptr(0, 16'h0000);
    do_op("R8 -X wraps unmapped", 0, 3, 0, 0, 0, 0, 0);
    do_op("R8 X+ wraps to zero", 1, 2, 0, 0, 0, 8'h12, 0);
    set_ptr(0, 16'h001A);
    do_op("R11 X+ store into own pair", 1, 2, 0, 0, 0, 8'hF0, 0);
    set_ptr(1, 16'h001D);
    do_op("R11 -Y store into own pair", 1, 3, 1, 0, 0, 8'h0F, 0);
    do_op("R12 poke during direct", 0, 0, 0, 0, 16'h0007, 0, 1);
    set_ptr(2, 16'h0120);
    do_op("R12 poke during sram", 0, 1, 2, 0, 0, 0, 1);
    do_op("R1 R5 check untouched", 0, 0, 0, 0, 16'h0005, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule